// File: doc/BRIEF.md
# Unrolled-Lane Result Reorder Collector

After a loop body has been replicated into N parallel lanes and every lane has run its share of rounds, each lane holds a private stream of results, one per round. This collector merges those streams back into a single output stream in the order the original sequential loop would have produced them. Each output element carries its position in that order, and the final element is flagged as last. The trip count R is known only at run time, so it need not be a multiple of N. When it is not, the final round has more lane results than the loop actually needed, and the block accepts and drops the extra ones.

A second mode handles loops that carry a value from one iteration to the next. In that mode only one value matters: the result of the true final iteration. The block computes how many lane slots of the final round lie beyond R, picks the lane that sits that many positions below the highest lane, and emits its final-round result as a single element. It consumes every other lane result silently. A run begins with a one-cycle start request that supplies R, the executed round count M and the mode. An inconsistent pair (R, M) is rejected with an error pulse, and the block then does no lane or output traffic.

Top module: `lane_reorder_collector`

## Requirements
- R1: A start request is taken only while the block is idle, and it captures the trip count, round count and mode. A start request during a run is ignored and does not change that run's output.
- R2: A start request is rejected unless M >= 1 and (M-1)*N < R <= M*N. On rejection err_o is high for exactly the one cycle after the request, no lane ready and no output valid is raised, and the block stays idle.
- R3: In independent mode (dep_mode_i = 0), output element k carries the result of lane k mod N from round floor(k/N), with index k. Indices start at 0 and rise by one per output handshake.
- R4: In independent mode the final round emits only lanes 0 to tc-1, where tc = R-(M-1)*N. The results of lanes tc to N-1 in that round are accepted with ready high and do not appear on the output, so every lane delivers exactly M results.
- R5: In dependent mode (dep_mode_i = 1), exactly one element is emitted: the final-round result of lane N-1-(M*N-R), with index 0 and the last flag set. All other lane results are consumed without output.
- R6: The last flag is high only on the final output element of a run (index R-1 in independent mode), and no output is valid after that element's handshake within the same run.
- R7: Lanes are served in turn, lane 0 to N-1 within each round and rounds in ascending order. At most one lane ready is high at a time, and only for the lane whose turn it is.
- R8: While the output is valid and not accepted, the current lane ready is low and the output data and index hold their values.
- R9: done_o is a one-cycle pulse in the cycle after the final lane transfer of a run. busy_o falls in that same cycle.
- R10: After reset the block is idle: busy_o, done_o, err_o, out_valid_o and all lane readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle run request |
| dep_mode_i | input | 1 | 1 = loop-carried mode, 0 = independent mode |
| trip_cnt_i | input | CNT_W | Required trip count R |
| rounds_i | input | CNT_W | Executed round count M |
| lane_valid_i | input | LANES | Per-lane result valid |
| lane_data_i | input | LANES*DATA_W | Per-lane result data, lane j at bits j*DATA_W upward |
| lane_ready_o | output | LANES | Per-lane result accept |
| out_valid_o | output | 1 | Ordered output valid |
| out_ready_i | input | 1 | Ordered output accept |
| out_data_o | output | DATA_W | Ordered output data |
| out_idx_o | output | CNT_W | Position of the element in the original iteration order |
| out_last_o | output | 1 | Final element of the run |
| done_o | output | 1 | Run finished, one-cycle pulse |
| err_o | output | 1 | Start request rejected, one-cycle pulse |
| busy_o | output | 1 | Run in progress |

## Verification
Output back-pressure and a fresh start request can land in the same cycle while a run is stalled. The bench provokes this by raising start with a different R and M during a long independent run whose output ready is held low two cycles in three. It judges the case by requiring that the run's output sequence, indices, last flag and lane consumption still match the values computed for the original configuration. The silent discard of surplus final-round lane results and the last output handshake can also fall in adjacent cycles. The bench checks that the done pulse follows the last lane transfer and not the last output.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lrc_state_e;
endpackage

// File: rtl/lrc_cfg_check.sv
// Validates (R, M) against the lane count and derives the final-round split.
module lrc_cfg_check #(
  parameter int LANES  = 4,
  parameter int CNT_W  = 16,
  parameter int LANE_W = 2,
  parameter int LCNT_W = 3
) (
  input  logic [CNT_W-1:0]  trip_i,
  input  logic [CNT_W-1:0]  rounds_i,
  output logic              ok_o,
  output logic [LCNT_W-1:0] tc_o,
  output logic [LANE_W-1:0] sel_o
);
  localparam int PROD_W = CNT_W + LANE_W + 1;

  logic [PROD_W-1:0] r_ext, hi, lo;

  always_comb begin
    r_ext = PROD_W'(trip_i);
    hi    = PROD_W'(rounds_i) * PROD_W'(LANES);
    lo    = hi - PROD_W'(LANES);
    ok_o  = (rounds_i != '0) && (r_ext > lo) && (r_ext <= hi);
    // kept lanes in the final round
    tc_o  = LCNT_W'(r_ext - lo);
    // loop-carried pick: highest lane minus surplus slots
    sel_o = LANE_W'(LANES - 1) - LANE_W'(hi - r_ext);
  end
endmodule

// File: rtl/lrc_seq.sv
module lrc_seq
  import lrc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CNT_W  = 16,
  parameter int LANE_W = 2,
  parameter int LCNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dep_i,
  input  logic [CNT_W-1:0]  trip_i,
  input  logic [CNT_W-1:0]  rounds_i,
  input  logic              cfg_ok_i,
  input  logic [LCNT_W-1:0] tc_i,
  input  logic [LANE_W-1:0] sel_i,
  input  logic              cur_valid_i,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              take_o,
  output logic              emit_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              last_o,
  output logic              done_o,
  output logic              err_o
);
  lrc_state_e        state_q;
  logic              mode_q;
  logic [CNT_W-1:0]  trip_q, rounds_q, round_q, idx_q;
  logic [LCNT_W-1:0] tc_q;
  logic [LANE_W-1:0] sel_q, lane_q;
  logic              done_q, err_q;
  logic              final_round, lane_end, xfer;

  always_comb begin
    busy_o      = (state_q == ST_RUN);
    final_round = (round_q == rounds_q - 1'b1);
    lane_end    = (lane_q == LANE_W'(LANES - 1));
    if (mode_q) emit_o = busy_o && final_round && (lane_q == sel_q);
    else        emit_o = busy_o && (!final_round || (LCNT_W'(lane_q) < tc_q));
    // surplus results are drained without waiting on the output
    take_o = busy_o && (emit_o ? out_ready_i : 1'b1);
    xfer   = take_o && cur_valid_i;
    last_o = emit_o && (mode_q || (idx_q == trip_q - 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      trip_q   <= '0;
      rounds_q <= '0;
      round_q  <= '0;
      idx_q    <= '0;
      tc_q     <= '0;
      sel_q    <= '0;
      lane_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cfg_ok_i) begin
              mode_q   <= dep_i;
              trip_q   <= trip_i;
              rounds_q <= rounds_i;
              tc_q     <= tc_i;
              sel_q    <= sel_i;
              round_q  <= '0;
              lane_q   <= '0;
              idx_q    <= '0;
              state_q  <= ST_RUN;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (xfer) begin
            if (emit_o) idx_q <= idx_q + 1'b1;
            if (lane_end) begin
              lane_q  <= '0;
              round_q <= round_q + 1'b1;
              if (final_round) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              lane_q <= lane_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_o = lane_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/lrc_lane_mux.sv
module lrc_lane_mux #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int LANE_W = 2
) (
  input  logic [LANE_W-1:0]       lane_i,
  input  logic                    take_i,
  input  logic [LANES-1:0]        lane_valid_i,
  input  logic [LANES*DATA_W-1:0] lane_data_i,
  output logic [LANES-1:0]        lane_ready_o,
  output logic                    cur_valid_o,
  output logic [DATA_W-1:0]       cur_data_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_rdy
    assign lane_ready_o[j] = take_i && (lane_i == LANE_W'(j));
  end

  always_comb begin
    cur_valid_o = 1'b0;
    cur_data_o  = '0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_i == LANE_W'(j)) begin
        cur_valid_o = lane_valid_i[j];
        cur_data_o  = lane_data_i[j*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/lane_reorder_collector.sv
module lane_reorder_collector #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    dep_mode_i,
  input  logic [CNT_W-1:0]        trip_cnt_i,
  input  logic [CNT_W-1:0]        rounds_i,
  input  logic [LANES-1:0]        lane_valid_i,
  input  logic [LANES*DATA_W-1:0] lane_data_i,
  output logic [LANES-1:0]        lane_ready_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [DATA_W-1:0]       out_data_o,
  output logic [CNT_W-1:0]        out_idx_o,
  output logic                    out_last_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    busy_o
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LCNT_W = $clog2(LANES + 1);

  logic              cfg_ok;
  logic [LCNT_W-1:0] cfg_tc;
  logic [LANE_W-1:0] cfg_sel, cur_lane;
  logic              take, emit, cur_valid;

  lrc_cfg_check #(
    .LANES(LANES), .CNT_W(CNT_W), .LANE_W(LANE_W), .LCNT_W(LCNT_W)
  ) u_cfg (
    .trip_i  (trip_cnt_i),
    .rounds_i(rounds_i),
    .ok_o    (cfg_ok),
    .tc_o    (cfg_tc),
    .sel_o   (cfg_sel)
  );

  lrc_seq #(
    .LANES(LANES), .CNT_W(CNT_W), .LANE_W(LANE_W), .LCNT_W(LCNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dep_i      (dep_mode_i),
    .trip_i     (trip_cnt_i),
    .rounds_i   (rounds_i),
    .cfg_ok_i   (cfg_ok),
    .tc_i       (cfg_tc),
    .sel_i      (cfg_sel),
    .cur_valid_i(cur_valid),
    .out_ready_i(out_ready_i),
    .busy_o     (busy_o),
    .lane_o     (cur_lane),
    .take_o     (take),
    .emit_o     (emit),
    .idx_o      (out_idx_o),
    .last_o     (out_last_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  lrc_lane_mux #(
    .LANES(LANES), .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_mux (
    .lane_i      (cur_lane),
    .take_i      (take),
    .lane_valid_i(lane_valid_i),
    .lane_data_i (lane_data_i),
    .lane_ready_o(lane_ready_o),
    .cur_valid_o (cur_valid),
    .cur_data_o  (out_data_o)
  );

  assign out_valid_o = emit && cur_valid;
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              dep_mode_i,
  input logic [LANES-1:0]  lane_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic [CNT_W-1:0]  out_idx_o,
  input logic              out_last_o,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_o
);
  logic run_dep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_dep_q <= 1'b0;
    else if (start_i && !busy_o) run_dep_q <= dep_mode_i;
  end

  assert_ready_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_ready_o));

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_idx_o));

  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=> out_idx_o == $past(out_idx_o) + 1'b1);

  assert_quiet_after_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);

  assert_dep_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && run_dep_q |-> out_idx_o == '0 && out_last_o);

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !out_valid_o && lane_ready_o == '0);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> lane_ready_o == '0 && !out_valid_o);
endmodule

bind lane_reorder_collector lrc_checker #(
  .LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_lrc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dep_mode_i  (dep_mode_i),
  .lane_ready_o(lane_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_idx_o   (out_idx_o),
  .out_last_o  (out_last_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .busy_o      (busy_o)
);

// File: tb/tb_lane_reorder_collector.sv
module tb_lane_reorder_collector;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            dep = 1'b0;
  logic [CW-1:0]   trip = '0;
  logic [CW-1:0]   rnds = '0;
  logic [N-1:0]    lane_valid;
  logic [N*DW-1:0] lane_data;
  logic [N-1:0]    lane_ready;
  logic            out_valid, out_ready, out_last, done, err, busy;
  logic [DW-1:0]   out_data;
  logic [CW-1:0]   out_idx;

  int errors = 0, checks = 0, cyc = 0;
  int ptr [N];
  int base [N];
  int lane_cnt = 0;
  bit stall_en = 1'b0;
  bit hs [N];
  bit hs_any, prev_hs_any, prev_wait;
  logic [DW-1:0] prev_data;
  logic [CW-1:0] prev_idx;
  int ord_bad = 0, hold_bad = 0, done_bad = 0, done_cnt = 0;
  int rec_n = 0;
  logic [DW-1:0] rec_data [64];
  logic [CW-1:0] rec_idx [64];
  logic          rec_last [64];

  always #10 clk = ~clk;

  lane_reorder_collector #(.LANES(N), .DATA_W(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dep_mode_i(dep),
    .trip_cnt_i(trip), .rounds_i(rnds), .lane_valid_i(lane_valid),
    .lane_data_i(lane_data), .lane_ready_o(lane_ready), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_idx_o(out_idx),
    .out_last_o(out_last), .done_o(done), .err_o(err), .busy_o(busy)
  );

  function automatic logic [DW-1:0] lane_val(int j, int r);
    return DW'(16'hA000 + j * 256 + r);
  endfunction

  always_comb begin
    for (int j = 0; j < N; j++) begin
      lane_valid[j]          = (ptr[j] - base[j]) < lane_cnt;
      lane_data[j*DW +: DW]  = lane_val(j, ptr[j] - base[j]);
    end
  end

  initial for (int j = 0; j < N; j++) begin ptr[j] = 0; base[j] = 0; end

  // lane and output handshakes land at the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_en ? ((cyc % 3) == 2) : 1'b1;
    for (int j = 0; j < N; j++) if (hs[j]) ptr[j] <= ptr[j] + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual cycles=%0d expected below 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial out_ready = 1'b1;

  // monitor sampled mid-cycle
  always @(negedge clk) begin
    int tot;
    tot = 0;
    hs_any = 1'b0;
    for (int j = 0; j < N; j++) begin
      hs[j] = lane_valid[j] && lane_ready[j];
      hs_any |= hs[j];
      tot += ptr[j] - base[j];
    end
    if (rst_n) begin
      if ($countones(lane_ready) > 1) ord_bad++;
      for (int j = 0; j < N; j++) if (lane_ready[j] && j != (tot % N)) ord_bad++;
      if (prev_wait && !(out_valid && out_data == prev_data && out_idx == prev_idx)) hold_bad++;
      if (prev_wait && lane_ready != '0 && !out_valid) hold_bad++;
      if (out_valid && !out_ready && lane_ready != '0) hold_bad++;
      if (done) begin
        done_cnt++;
        if (!prev_hs_any || busy) done_bad++;
      end
      if (out_valid && out_ready && rec_n < 64) begin
        rec_data[rec_n] = out_data;
        rec_idx[rec_n]  = out_idx;
        rec_last[rec_n] = out_last;
        rec_n++;
      end
    end
    prev_wait   = out_valid && !out_ready;
    prev_data   = out_data;
    prev_idx    = out_idx;
    prev_hs_any = hs_any;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int r, int m, bit d, bit st, bit inject);
    int exp_n, bad, first_bad, lbad, cons_bad, t;
    bit fin;
    @(negedge clk);
    for (int j = 0; j < N; j++) base[j] = ptr[j];
    lane_cnt = m; stall_en = st;
    rec_n = 0; ord_bad = 0; hold_bad = 0; done_bad = 0; done_cnt = 0;
    trip = CW'(r); rnds = CW'(m); dep = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!err, "R2", "error on a legal config", int'(err), 0);
    t = 0; fin = 1'b0;
    while (!fin && t < 3000) begin
      if (inject && t == 3) begin
        trip = 2; rnds = 1; dep = ~d; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      t++;
      if (done_cnt > 0) fin = 1'b1;
    end
    start = 1'b0; stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9", "done pulses in run", done_cnt, 1);
    check(done_bad == 0, "R9", "done not one cycle after final lane transfer", done_bad, 0);
    check(ord_bad == 0, "R7", "lane ready out of turn", ord_bad, 0);
    check(hold_bad == 0, "R8", "output not held under back-pressure", hold_bad, 0);
    cons_bad = 0;
    for (int j = 0; j < N; j++) if (ptr[j] - base[j] != m) cons_bad++;
    check(cons_bad == 0, "R4", "lanes not fully consumed", cons_bad, 0);
    exp_n = d ? 1 : r;
    check(rec_n == exp_n, d ? "R5" : "R3", "output count", rec_n, exp_n);
    bad = 0; first_bad = -1; lbad = 0;
    for (int k = 0; k < rec_n && k < exp_n; k++) begin
      logic [DW-1:0] ed;
      ed = d ? lane_val(N - 1 - (m * N - r), m - 1) : lane_val(k % N, k / N);
      if (rec_data[k] != ed || rec_idx[k] != CW'(k)) begin
        bad++;
        if (first_bad < 0) begin
          first_bad = k;
          $display("  element %0d: data=%h idx=%0d expected data=%h idx=%0d",
                   k, rec_data[k], rec_idx[k], ed, k);
        end
      end
      if (rec_last[k] != (k == exp_n - 1)) lbad++;
    end
    check(bad == 0, d ? "R5" : "R3", "mismatching elements", bad, 0);
    check(lbad == 0, "R6", "last flag errors", lbad, 0);
    if (inject) check(bad == 0 && rec_n == exp_n, "R1", "start during run altered output", bad, 0);
  endtask

  task automatic run_err(int r, int m);
    int moved;
    @(negedge clk);
    for (int j = 0; j < N; j++) base[j] = ptr[j];
    lane_cnt = 8; rec_n = 0;
    trip = CW'(r); rnds = CW'(m); dep = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R2", "error pulse after bad start", int'(err), 1);
    check(!busy, "R2", "busy after bad start", int'(busy), 0);
    @(negedge clk);
    check(err == 1'b0, "R2", "error pulse width", int'(err), 0);
    repeat (4) @(negedge clk);
    moved = 0;
    for (int j = 0; j < N; j++) moved += ptr[j] - base[j];
    check(moved == 0 && rec_n == 0, "R2", "traffic after bad start", moved + rec_n, 0);
    lane_cnt = 0;
  endtask

  // {R, M, dep, stall}
  localparam logic [33:0] VEC [9] = '{
    {16'd8,  16'd2, 1'b0, 1'b0},
    {16'd5,  16'd2, 1'b0, 1'b0},
    {16'd7,  16'd2, 1'b0, 1'b1},
    {16'd1,  16'd1, 1'b0, 1'b0},
    {16'd13, 16'd4, 1'b0, 1'b1},
    {16'd6,  16'd2, 1'b1, 1'b0},
    {16'd8,  16'd2, 1'b1, 1'b1},
    {16'd9,  16'd3, 1'b1, 1'b0},
    {16'd4,  16'd1, 1'b1, 1'b0}
  };

  initial begin
    repeat (2) @(negedge clk);
    check(!busy && !done && !err && !out_valid && lane_ready == '0, "R10",
          "outputs during reset", int'({busy, done, err, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && lane_ready == '0, "R10", "idle after reset", int'(lane_ready), 0);
    for (int v = 0; v < 9; v++)
      run_vec(int'(VEC[v][33:18]), int'(VEC[v][17:2]), VEC[v][1], VEC[v][0], 1'b0);
    run_vec(14, 4, 1'b0, 1'b1, 1'b1);  // R1 start while stalled
    run_err(9, 2);                     // R2 above M*N
    run_err(4, 2);                     // R2 not above (M-1)*N
    run_err(3, 0);                     // R2 zero rounds
    run_vec(3, 1, 1'b0, 1'b0, 1'b0);   // R4 legal again after errors
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule